// File: doc/BRIEF.md
# Processor Clock, Reset and Ready Generator

This block derives the timing signals a processor core and its peripherals need from one fast reference. It runs on a single system clock. The reference arrives as one-cycle tick pulses from one of two sources: a crystal-derived tick or an externally supplied tick. A source-select input chooses which one is used. From the chosen ticks the block builds three outputs. The first is a processor clock at one third of the tick rate, high for one tick period out of three. The second is a peripheral clock at one sixth of the tick rate with an even duty cycle, phase-locked to the processor clock. The third is an oscillator pulse that repeats every reference tick.

An active-low power-on reset input is synchronized and holds every divider at a known phase. The processor reset output stays high until the first falling edge of the processor clock after release. Two bus-ready requests, each gated by its own active-low enable, are merged and passed through a synchronizer. The synchronizer depth is one or two stages, chosen at run time.

Top module: `cpuclk_gen`

## Requirements
- R1: After reset release the processor clock starts low. Counting accepted reference ticks from one, the processor clock is high only after ticks 2, 5, 8 and so on (count mod 3 = 2), which gives one high tick period in three. It changes only at a clock edge that samples an accepted tick, and the new value is visible after that edge.
- R2: The peripheral clock starts low and inverts at every rising edge of the processor clock, on the same clock edge. This makes it one sixth of the tick rate with a 50% duty cycle.
- R3: The oscillator output is high for exactly the cycle that follows each clock edge sampling an accepted tick, and low otherwise.
- R4: With the source select at 1 only the external tick is accepted. With it at 0 only the crystal tick is accepted. The unselected tick has no effect on any output.
- R5: While the reset input is low, every output is at its reset value by the second clock edge: both clocks low, oscillator low, ready low, processor reset high. The reset input passes two synchronizer stages after release, so ticks sampled at the first two clock edges after release are ignored.
- R6: After release the processor reset output stays high. It drops on the edge where the processor clock falls for the first time (the third accepted tick), and then stays low until the next reset.
- R7: The merged ready request is (ready A and enable A low) or (ready B and enable B low). A ready request whose enable is high has no effect.
- R8: With the depth select at 0 (one stage), the ready output equals the merged request sampled at the previous clock edge.
- R9: With the depth select at 1 (two stages), the ready output equals the merged request sampled two clock edges earlier. The depth select acts on the output without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the reference |
| pwr_rst_n_i | input | 1 | Asynchronous power-on reset, active low |
| src_ext_i | input | 1 | Reference source select: 1 external tick, 0 crystal tick |
| xtal_tick_i | input | 1 | Crystal reference tick, one cycle per period |
| ext_tick_i | input | 1 | External reference tick, one cycle per period |
| rdy_a_i | input | 1 | Bus ready request A |
| rdy_a_en_n_i | input | 1 | Enable for request A, active low |
| rdy_b_i | input | 1 | Bus ready request B |
| rdy_b_en_n_i | input | 1 | Enable for request B, active low |
| rdy_depth_i | input | 1 | Ready synchronizer depth: 0 one stage, 1 two stages |
| osc_o | output | 1 | One pulse per accepted reference tick |
| cpu_clk_o | output | 1 | Processor clock, divide by 3, one-third duty |
| per_clk_o | output | 1 | Peripheral clock, divide by 6, 50% duty |
| cpu_reset_o | output | 1 | Processor reset, active high |
| ready_o | output | 1 | Synchronized ready |

## Verification
Two events share a single clock edge here. The release of the processor reset lands on the same edge as the first falling edge of the processor clock. The peripheral clock also inverts on the very edge where the processor clock rises. The bench provokes the first by releasing reset and then supplying a tick on every cycle, and again with random tick gaps and a mid-run reset. It provokes the second through long random tick streams. A cycle-accurate model in the bench counts accepted ticks and predicts every output at every cycle. The bound checker confirms that the reset output only falls with the processor clock, and that the peripheral clock only moves when the processor clock rises.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;

    // Ready synchronizer depth select encoding
    typedef enum logic {
        RDY_ONE = 1'b0,
        RDY_TWO = 1'b1
    } rdy_depth_e;

    // Derived clock outputs carried as one registered bundle
    typedef struct packed {
        logic cpu;
        logic per;
        logic osc;
    } clk_bundle_t;

    // Two qualified ready requests
    typedef struct packed {
        logic a;
        logic a_en_n;
        logic b;
        logic b_en_n;
    } rdy_pair_t;

    function automatic logic rdy_merge(input rdy_pair_t p);
        return (p.a & ~p.a_en_n) | (p.b & ~p.b_en_n);
    endfunction

    function automatic logic tick_pick(input logic use_ext, input logic xt, input logic et);
        return use_ext ? et : xt;
    endfunction

endpackage

// File: rtl/cpuclk_rst_sync.sv
module cpuclk_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic arst_n_i,
    output logic rst_o
);
    logic [STAGES-1:0] sync_q;

    // Asserts at once, releases after STAGES clock edges
    always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], 1'b0};
        end
    end

    assign rst_o = sync_q[STAGES-1];
endmodule

// File: rtl/cpuclk_divider.sv
module cpuclk_divider
    import cpuclk_pkg::*;
#(
    parameter int unsigned DIV = 3
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        tick_i,
    output clk_bundle_t clks_o,
    output logic        cpu_reset_o
);
    localparam int unsigned     PH_W  = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PH_W-1:0] PH_HI = PH_W'(DIV - 1);

    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] ph_d;
    clk_bundle_t     clk_q;
    logic            cpu_rst_q;
    logic            rise_d;
    logic            fall_d;

    always_comb begin
        ph_d   = (ph_q == PH_HI) ? '0 : ph_q + PH_W'(1);
        rise_d = tick_i & (ph_d == PH_HI);
        fall_d = tick_i & (ph_d == '0);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ph_q      <= '0;
            clk_q     <= '0;
            cpu_rst_q <= 1'b1;
        end else begin
            clk_q.osc <= tick_i;
            if (tick_i) begin
                ph_q      <= ph_d;
                clk_q.cpu <= (ph_d == PH_HI);
            end
            if (rise_d) begin
                clk_q.per <= ~clk_q.per;
            end
            if (fall_d) begin
                cpu_rst_q <= 1'b0;
            end
        end
    end

    assign clks_o      = clk_q;
    assign cpu_reset_o = cpu_rst_q;
endmodule

// File: rtl/cpuclk_ready_sync.sv
module cpuclk_ready_sync
    import cpuclk_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       req_i,
    input  rdy_depth_e depth_i,
    output logic       ready_o
);
    logic [STAGES-1:0] st_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                st_q[g] <= 1'b0;
            end else if (g == 0) begin
                st_q[g] <= req_i;
            end else begin
                st_q[g] <= st_q[(g == 0) ? 0 : g - 1];
            end
        end
    end

    assign ready_o = (depth_i == RDY_TWO) ? st_q[STAGES-1] : st_q[0];
endmodule

// File: rtl/cpuclk_gen.sv
module cpuclk_gen
    import cpuclk_pkg::*;
#(
    parameter int unsigned DIV        = 3,
    parameter int unsigned RST_STAGES = 2,
    parameter int unsigned RDY_STAGES = 2
) (
    input  logic clk_i,
    input  logic pwr_rst_n_i,
    input  logic src_ext_i,
    input  logic xtal_tick_i,
    input  logic ext_tick_i,
    input  logic rdy_a_i,
    input  logic rdy_a_en_n_i,
    input  logic rdy_b_i,
    input  logic rdy_b_en_n_i,
    input  logic rdy_depth_i,
    output logic osc_o,
    output logic cpu_clk_o,
    output logic per_clk_o,
    output logic cpu_reset_o,
    output logic ready_o
);
    logic        core_rst;
    logic        ref_tick;
    logic        rdy_req;
    rdy_pair_t   rdy_pair;
    clk_bundle_t clks;
    rdy_depth_e  depth;

    assign ref_tick = tick_pick(src_ext_i, xtal_tick_i, ext_tick_i);
    assign rdy_pair = '{a: rdy_a_i, a_en_n: rdy_a_en_n_i, b: rdy_b_i, b_en_n: rdy_b_en_n_i};
    assign rdy_req  = rdy_merge(rdy_pair);
    assign depth    = rdy_depth_e'(rdy_depth_i);

    cpuclk_rst_sync #(.STAGES(RST_STAGES)) u_rst (
        .clk_i    (clk_i),
        .arst_n_i (pwr_rst_n_i),
        .rst_o    (core_rst)
    );

    cpuclk_divider #(.DIV(DIV)) u_div (
        .clk_i       (clk_i),
        .rst_i       (core_rst),
        .tick_i      (ref_tick),
        .clks_o      (clks),
        .cpu_reset_o (cpu_reset_o)
    );

    cpuclk_ready_sync #(.STAGES(RDY_STAGES)) u_rdy (
        .clk_i   (clk_i),
        .rst_i   (core_rst),
        .req_i   (rdy_req),
        .depth_i (depth),
        .ready_o (ready_o)
    );

    assign osc_o     = clks.osc;
    assign cpu_clk_o = clks.cpu;
    assign per_clk_o = clks.per;
endmodule

// File: rtl/cpuclk_gen_chk.sv
module cpuclk_gen_chk (
    input logic clk_i,
    input logic core_rst,
    input logic src_ext_i,
    input logic xtal_tick_i,
    input logic ext_tick_i,
    input logic rdy_a_i,
    input logic rdy_a_en_n_i,
    input logic rdy_b_i,
    input logic rdy_b_en_n_i,
    input logic rdy_depth_i,
    input logic osc_o,
    input logic cpu_clk_o,
    input logic per_clk_o,
    input logic cpu_reset_o,
    input logic ready_o
);
    logic       seen_q = 1'b0;
    logic [1:0] live_q = 2'b00;
    logic       tk;
    logic       req;

    assign tk  = src_ext_i ? ext_tick_i : xtal_tick_i;
    assign req = (rdy_a_i & ~rdy_a_en_n_i) | (rdy_b_i & ~rdy_b_en_n_i);

    always_ff @(posedge clk_i) begin
        if (core_rst) begin
            seen_q <= 1'b1;
            live_q <= 2'b00;
        end else if (live_q != 2'b11) begin
            live_q <= live_q + 2'b01;
        end
    end

    // R1
    cpu_high_once_chk: assert property (@(posedge clk_i) disable iff (core_rst || !seen_q)
        (tk && cpu_clk_o) |=> !cpu_clk_o);

    // R1
    cpu_hold_chk: assert property (@(posedge clk_i) disable iff (core_rst || !seen_q)
        !tk |=> $stable(cpu_clk_o));

    // R2
    per_edge_chk: assert property (@(posedge clk_i) disable iff (core_rst || !seen_q)
        !$stable(per_clk_o) |-> $rose(cpu_clk_o));

    // R3
    osc_on_chk: assert property (@(posedge clk_i) disable iff (core_rst || !seen_q)
        tk |=> osc_o);

    // R3
    osc_off_chk: assert property (@(posedge clk_i) disable iff (core_rst || !seen_q)
        !tk |=> !osc_o);

    // R6
    rst_fall_chk: assert property (@(posedge clk_i) disable iff (core_rst || !seen_q)
        $fell(cpu_reset_o) |-> $fell(cpu_clk_o));

    // R6
    rst_stay_low_chk: assert property (@(posedge clk_i) disable iff (core_rst || !seen_q)
        !cpu_reset_o |=> !cpu_reset_o);

    // R8
    rdy_one_chk: assert property (@(posedge clk_i) disable iff (core_rst || !seen_q)
        (live_q >= 2'd2 && !rdy_depth_i) |-> (ready_o == $past(req)));

    // R9
    rdy_two_chk: assert property (@(posedge clk_i) disable iff (core_rst || !seen_q)
        (live_q >= 2'd2 && rdy_depth_i) |-> (ready_o == $past(req, 2)));
endmodule

bind cpuclk_gen cpuclk_gen_chk u_chk (
    .clk_i        (clk_i),
    .core_rst     (core_rst),
    .src_ext_i    (src_ext_i),
    .xtal_tick_i  (xtal_tick_i),
    .ext_tick_i   (ext_tick_i),
    .rdy_a_i      (rdy_a_i),
    .rdy_a_en_n_i (rdy_a_en_n_i),
    .rdy_b_i      (rdy_b_i),
    .rdy_b_en_n_i (rdy_b_en_n_i),
    .rdy_depth_i  (rdy_depth_i),
    .osc_o        (osc_o),
    .cpu_clk_o    (cpu_clk_o),
    .per_clk_o    (per_clk_o),
    .cpu_reset_o  (cpu_reset_o),
    .ready_o      (ready_o)
);

// File: tb/cpuclk_gen_tb.sv
`timescale 1ns/1ps
module cpuclk_gen_tb;
    logic clk = 1'b0;
    logic pwr_rst_n = 1'b0;
    logic src_ext = 1'b0, xtal_tick = 1'b0, ext_tick = 1'b0;
    logic rdy_a = 1'b0, rdy_a_en_n = 1'b1, rdy_b = 1'b0, rdy_b_en_n = 1'b1;
    logic rdy_depth = 1'b0;
    logic osc, cpu_clk, per_clk, cpu_reset, ready;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    bit chk_en = 1'b0;

    // bench model state
    bit m_r0 = 1'b1, m_r1 = 1'b1;
    int m_ph = 0;
    bit m_cpu = 0, m_per = 0, m_osc = 0, m_rst = 1, m_s1 = 0, m_s2 = 0;

    always #10 clk = ~clk;

    cpuclk_gen u_dut (
        .clk_i        (clk),
        .pwr_rst_n_i  (pwr_rst_n),
        .src_ext_i    (src_ext),
        .xtal_tick_i  (xtal_tick),
        .ext_tick_i   (ext_tick),
        .rdy_a_i      (rdy_a),
        .rdy_a_en_n_i (rdy_a_en_n),
        .rdy_b_i      (rdy_b),
        .rdy_b_en_n_i (rdy_b_en_n),
        .rdy_depth_i  (rdy_depth),
        .osc_o        (osc),
        .cpu_clk_o    (cpu_clk),
        .per_clk_o    (per_clk),
        .cpu_reset_o  (cpu_reset),
        .ready_o      (ready)
    );

    function automatic bit req_merge(bit a, bit an, bit b, bit bn);
        return (a & ~an) | (b & ~bn);
    endfunction

    task automatic check(string req, string phase, bit act, bit exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s (%s) t=%0t actual=%0b expected=%0b", req, phase, $time, act, exp);
        end
    endtask

    task automatic cyc(string phase, bit rn, bit src, bit xt, bit et,
                       bit a, bit an, bit b, bit bn, bit dep);
        bit core, t, r;
        pwr_rst_n = rn; src_ext = src; xtal_tick = xt; ext_tick = et;
        rdy_a = a; rdy_a_en_n = an; rdy_b = b; rdy_b_en_n = bn; rdy_depth = dep;
        if (!rn) begin m_r0 = 1; m_r1 = 1; end
        @(posedge clk);
        core = m_r1;
        t = src ? et : xt;
        r = req_merge(a, an, b, bn);
        if (core) begin
            m_ph = 0; m_cpu = 0; m_per = 0; m_osc = 0; m_rst = 1; m_s1 = 0; m_s2 = 0;
        end else begin
            m_osc = t;
            m_s2 = m_s1;
            m_s1 = r;
            if (t) begin
                m_ph = (m_ph + 1) % 3;
                m_cpu = (m_ph == 2);
                if (m_ph == 2) m_per = ~m_per;
                if (m_ph == 0) m_rst = 0;
            end
        end
        m_r1 = rn ? m_r0 : 1'b1;
        m_r0 = ~rn;
        @(negedge clk);
        if (chk_en) begin
            check("R1", phase, cpu_clk, m_cpu);
            check("R2", phase, per_clk, m_per);
            check("R3", phase, osc, m_osc);
            check("R6", phase, cpu_reset, m_rst);
            check(dep ? "R9" : "R8", phase, ready, dep ? m_s2 : m_s1);
        end
    endtask

    initial begin
        void'($urandom(32'd7321));
        @(negedge clk);
        // R5: hold reset, skip the first two cycles before the synchronizer settles
        for (int i = 0; i < 2; i++) cyc("R5", 0, 0, 1, 1, 1, 0, 1, 0, 0);
        chk_en = 1'b1;
        for (int i = 0; i < 3; i++) cyc("R5", 0, 0, 1, 1, 1, 0, 1, 0, 1);
        // R5/R6: release with a tick every cycle; first two ticks ignored
        for (int i = 0; i < 14; i++) cyc("R6", 1, 0, 1, 0, 0, 1, 0, 1, 0);
        // R4: external selected, only crystal ticks toggle -> no effect
        for (int i = 0; i < 10; i++) cyc("R4", 1, 1, 1, 0, 0, 1, 0, 1, 0);
        // R4: external selected and ticking
        for (int i = 0; i < 10; i++) cyc("R4", 1, 1, 0, 1, 0, 1, 0, 1, 0);
        // R7: requests with enables high are ignored
        for (int i = 0; i < 4; i++) cyc("R7", 1, 0, 0, 0, 1, 1, 1, 1, 0);
        for (int i = 0; i < 4; i++) cyc("R7", 1, 0, 0, 0, 0, 0, 1, 0, 1);
        for (int i = 0; i < 4; i++) cyc("R7", 1, 0, 0, 0, 1, 1, 0, 1, 1);
        for (int i = 0; i < 4; i++) cyc("R7", 1, 0, 0, 0, 1, 0, 0, 1, 0);
        // R8/R9: single-cycle pulse with depth flip
        cyc("R8", 1, 0, 0, 0, 1, 0, 0, 1, 0);
        cyc("R9", 1, 0, 0, 0, 0, 0, 0, 1, 1);
        cyc("R8", 1, 0, 0, 0, 0, 0, 0, 1, 0);
        cyc("R9", 1, 0, 0, 0, 0, 0, 0, 1, 1);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            bit dep = ((i / 37) % 2) == 1;
            cyc("R7", 1, $urandom % 2, $urandom % 2, $urandom % 3 == 0,
                $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, dep);
        end
        // R5: mid-run reset while ticking
        for (int i = 0; i < 3; i++) cyc("R5", 0, 0, 1, 1, 1, 0, 0, 1, 0);
        for (int i = 0; i < 500; i++) begin
            cyc("R6", 1, 0, $urandom % 2, $urandom % 2,
                $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule